// File: doc/BRIEF.md
# Retry-on-Error Transmit Controller

This block sits beside a transmit segment buffer and decides, one segment at a time, whether the segment held in that buffer is sent for the first time, sent again, released, or abandoned. A new segment is sent only when nothing is outstanding. Each transmission starts a timeout timer. When a positive acknowledgement arrives for the outstanding sequence number, the buffer is told to advance and the sequence number steps forward. When a negative acknowledgement arrives, or the timer runs out, the buffer is told to send the same segment again. When the attempt limit is used up without an acknowledgement, the block raises an error and requests a link restart.

The acknowledgement and negative acknowledgement inputs carry management messages that an upstream receiver has already decoded. A message whose sequence number differs from the outstanding one has no effect. A small status section flags any retry message that arrives while the retry feature is switched off. It also holds a priority-buffer overflow flag high until that buffer has drained, but only while retry is enabled.

The controller has six states. IDLE waits for a segment. SEND issues the first transmission. WAIT runs the timer. RESEND issues a repeat transmission. ADVANCE releases the acknowledged segment. RESTART gives up. The transitions are as follows. IDLE goes to SEND when retry is enabled and a segment is ready. SEND goes to WAIT. WAIT goes to ADVANCE on a matching acknowledgement. WAIT goes to RESEND on a matching negative acknowledgement or a timeout while attempts remain. WAIT goes to RESTART on either of those once the limit is reached. RESEND goes to WAIT. ADVANCE and RESTART both go back to IDLE.

Top module: `roe_tx_ctrl`

## Requirements
- R1: After reset, all command and status outputs are 0 and `tx_seq` is 0.
- R2: In IDLE with `roe_en`=1 and `seg_ready`=1, `send_go` pulses for exactly one cycle and `tx_seq` gives the outstanding sequence number. No further segment starts until the outstanding one is released or abandoned.
- R3: In WAIT, an `ack_vld` whose `msg_seq` equals `tx_seq` causes one `advance` pulse in the next cycle. After that pulse, `tx_seq` is incremented modulo 2^SEQ_W and a new segment may start.
- R4: In WAIT, a `nack_vld` whose `msg_seq` equals `tx_seq` causes one `resend_go` pulse in the next cycle, with `tmo_stat` low.
- R5: The timer reloads on every `send_go` and `resend_go`. If no matching message arrives, `resend_go` and `tmo_stat` pulse together exactly TMO_CYC+1 cycles after the previous transmission pulse.
- R6: An `ack_vld` or `nack_vld` whose `msg_seq` differs from `tx_seq` produces no command and leaves `tx_seq` unchanged.
- R7: Once a segment has been transmitted MAX_TX times (default 4) without an acknowledgement, the next timeout or matching `nack_vld` pulses `link_restart` and `limit_err` together instead of a resend. The attempt count then clears, so the next segment again gets MAX_TX transmissions.
- R8: When a matching `ack_vld` and `nack_vld` arrive in the same cycle, the acknowledgement wins and `advance` pulses.
- R9: With `roe_en`=0, each cycle with `ack_vld` or `nack_vld` high pulses `msg_err` in the following cycle, and `seg_ready` starts no transmission.
- R10: With `roe_en`=1, `hp_ovf_flag` rises the cycle after `hp_ovf_evt` and stays high until the cycle after `hp_empty`. With `roe_en`=0 it is a one-cycle copy of `hp_ovf_evt`, delayed by one cycle.
- R11: At most one of `send_go`, `resend_go`, `advance` and `link_restart` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| roe_en | input | 1 | Retry feature enable; change only while idle |
| seg_ready | input | 1 | Segment buffer holds a new segment to send |
| ack_vld | input | 1 | Decoded positive acknowledgement |
| nack_vld | input | 1 | Decoded negative acknowledgement |
| msg_seq | input | SEQ_W | Sequence number carried by the message |
| hp_ovf_evt | input | 1 | Priority transmit buffer overflow event |
| hp_empty | input | 1 | Priority transmit buffer is drained |
| send_go | output | 1 | Send the new segment |
| resend_go | output | 1 | Send the outstanding segment again |
| advance | output | 1 | Release the outstanding segment |
| tx_seq | output | SEQ_W | Outstanding sequence number |
| tmo_stat | output | 1 | Current resend was caused by a timeout |
| link_restart | output | 1 | Request link restart |
| limit_err | output | 1 | Attempt limit reached without acknowledgement |
| msg_err | output | 1 | Retry message received while retry is disabled |
| hp_ovf_flag | output | 1 | Priority buffer overflow flag |

## Verification
The segments are released in four different ways: by a prompt acknowledgement, by a negative acknowledgement followed by an acknowledgement, by timeouts alone, and by a run of negative acknowledgements. Each expected command, with its sequence number, goes onto a scoreboard. The timeout cases also check the exact spacing between pulses, which shows whether the timer reloads on every transmission. Messages with the wrong sequence number, and an acknowledgement that arrives together with a negative one, separate a correct sequence compare and the acknowledgement priority from a controller that reacts to any message. Two restarts in a row, the first from timeouts and the second from negative acknowledgements, show that the attempt count clears on restart and that both resend paths reach the limit.

// File: rtl/roe_pkg.sv
package roe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RESEND,
        ST_ADVANCE,
        ST_RESTART
    } roe_state_e;
endpackage

// File: rtl/roe_timer.sv
module roe_timer #(
    parameter int TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);

    // R5: a fresh load never expires in the following cycle
    p_no_early_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
endmodule

// File: rtl/roe_status.sv
module roe_status (
    input  logic clk,
    input  logic rst_n,
    input  logic roe_en,
    input  logic ack_vld,
    input  logic nack_vld,
    input  logic hp_ovf_evt,
    input  logic hp_empty,
    output logic msg_err,
    output logic hp_ovf_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_err     <= 1'b0;
            hp_ovf_flag <= 1'b0;
        end else begin
            msg_err <= !roe_en && (ack_vld || nack_vld);
            if (hp_ovf_evt)
                hp_ovf_flag <= 1'b1;
            else if (!roe_en || hp_empty)
                hp_ovf_flag <= 1'b0;
        end
    end

    p_msg_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> !$past(roe_en));

    p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (roe_en && hp_ovf_flag && !hp_empty) |=> hp_ovf_flag);
endmodule

// File: rtl/roe_tx_ctrl.sv
module roe_tx_ctrl
    import roe_pkg::*;
#(
    parameter int SEQ_W   = 4,
    parameter int MAX_TX  = 4,
    parameter int TMO_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roe_en,
    input  logic             seg_ready,
    input  logic             ack_vld,
    input  logic             nack_vld,
    input  logic [SEQ_W-1:0] msg_seq,
    input  logic             hp_ovf_evt,
    input  logic             hp_empty,
    output logic             send_go,
    output logic             resend_go,
    output logic             advance,
    output logic [SEQ_W-1:0] tx_seq,
    output logic             tmo_stat,
    output logic             link_restart,
    output logic             limit_err,
    output logic             msg_err,
    output logic             hp_ovf_flag
);
    localparam int ATT_W = $clog2(MAX_TX + 1);
    localparam logic [ATT_W-1:0] ATT_MAX = ATT_W'(MAX_TX);

    roe_state_e        state, nxt;
    logic [ATT_W-1:0]  tx_cnt;
    logic [SEQ_W-1:0]  cur_seq;
    logic              tmo_cause;
    logic              expired;
    logic              ack_hit, nack_hit, at_limit;

    assign ack_hit  = roe_en && ack_vld  && (msg_seq == cur_seq);
    assign nack_hit = roe_en && nack_vld && (msg_seq == cur_seq);
    assign at_limit = (tx_cnt >= ATT_MAX);

    roe_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (send_go || resend_go),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    roe_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .roe_en      (roe_en),
        .ack_vld     (ack_vld),
        .nack_vld    (nack_vld),
        .hp_ovf_evt  (hp_ovf_evt),
        .hp_empty    (hp_empty),
        .msg_err     (msg_err),
        .hp_ovf_flag (hp_ovf_flag)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (roe_en && seg_ready) nxt = ST_SEND;
            ST_SEND:    nxt = ST_WAIT;
            ST_WAIT: begin
                if (ack_hit)
                    nxt = ST_ADVANCE;
                else if (nack_hit || expired)
                    nxt = at_limit ? ST_RESTART : ST_RESEND;
            end
            ST_RESEND:  nxt = ST_WAIT;
            ST_ADVANCE: nxt = ST_IDLE;
            ST_RESTART: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt    <= '0;
            cur_seq   <= '0;
            tmo_cause <= 1'b0;
        end else begin
            tmo_cause <= (state == ST_WAIT) && !ack_hit && !nack_hit && expired;
            unique case (state)
                ST_SEND:    tx_cnt <= ATT_W'(1);
                ST_RESEND:  tx_cnt <= tx_cnt + 1'b1;
                ST_ADVANCE: begin
                    tx_cnt  <= '0;
                    cur_seq <= cur_seq + 1'b1;
                end
                ST_RESTART: tx_cnt <= '0;
                default:    ;
            endcase
        end
    end

    always_comb begin
        send_go      = 1'b0;
        resend_go    = 1'b0;
        advance      = 1'b0;
        link_restart = 1'b0;
        limit_err    = 1'b0;
        tmo_stat     = 1'b0;
        unique case (state)
            ST_SEND:    send_go = 1'b1;
            ST_RESEND: begin
                resend_go = 1'b1;
                tmo_stat  = tmo_cause;
            end
            ST_ADVANCE: advance = 1'b1;
            ST_RESTART: begin
                link_restart = 1'b1;
                limit_err    = 1'b1;
            end
            default:    ;
        endcase
    end

    assign tx_seq = cur_seq;

    p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_go, resend_go, advance, link_restart}));

    p_resend_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resend_go |-> $past(state) == ST_WAIT);

    p_restart_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_restart |-> tx_cnt == ATT_MAX);

    p_adv_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> tx_seq == $past(tx_seq) + 1'b1);

    p_send_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        send_go |-> $past(state) == ST_IDLE && $past(roe_en));
endmodule

// File: tb/sim_roe_tx_ctrl.sv
module sim_roe_tx_ctrl;
    localparam int SEQ_W = 4;
    localparam int MAXT  = 4;
    localparam int TMO   = 16;
    localparam int K_SEND = 0, K_RESEND = 1, K_RESEND_TMO = 2, K_ADV = 3, K_RESTART = 4;

    typedef struct {
        int kind;
        int seq;
        int gap;
        string req;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic roe_en = 1, seg_ready = 0, ack_vld = 0, nack_vld = 0;
    logic [SEQ_W-1:0] msg_seq = '0;
    logic hp_ovf_evt = 0, hp_empty = 0;
    logic send_go, resend_go, advance, tmo_stat, link_restart, limit_err, msg_err, hp_ovf_flag;
    logic [SEQ_W-1:0] tx_seq;

    int n_chk = 0, n_fail = 0, cyc = 0, last_cmd = 0;
    bit done = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    roe_tx_ctrl #(.SEQ_W(SEQ_W), .MAX_TX(MAXT), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .roe_en(roe_en), .seg_ready(seg_ready),
        .ack_vld(ack_vld), .nack_vld(nack_vld), .msg_seq(msg_seq),
        .hp_ovf_evt(hp_ovf_evt), .hp_empty(hp_empty),
        .send_go(send_go), .resend_go(resend_go), .advance(advance), .tx_seq(tx_seq),
        .tmo_stat(tmo_stat), .link_restart(link_restart), .limit_err(limit_err),
        .msg_err(msg_err), .hp_ovf_flag(hp_ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input int kind, input int seq, input int gap, input string req);
        exp_t e;
        e.kind = kind; e.seq = seq; e.gap = gap; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: pops the scoreboard whenever a command appears
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (send_go || resend_go || advance || link_restart) begin
                int k;
                k = send_go ? K_SEND : resend_go ? (tmo_stat ? K_RESEND_TMO : K_RESEND)
                  : advance ? K_ADV : K_RESTART;
                if (q.size() == 0) begin
                    chk(0, "R6", "unexpected command kind", k, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(k == e.kind, e.req, "command kind", k, e.kind);
                    chk(int'(tx_seq) == e.seq, e.req, "command seq", tx_seq, e.seq);
                    if (e.gap != 0)
                        chk(cyc - last_cmd == e.gap, e.req, "pulse spacing", cyc - last_cmd, e.gap);
                    if (k == K_RESTART)
                        chk(limit_err == 1'b1, "R7", "limit_err with restart", limit_err, 1);
                end
                last_cmd = cyc;
            end
        end
    end

    task automatic send_seg(input int seq, input string req);
        expect_cmd(K_SEND, seq, 0, req);
        seg_ready = 1;
        @(negedge clk);
        seg_ready = 0;
    endtask

    task automatic pulse_msg(input bit a, input bit n, input int seq);
        ack_vld = a; nack_vld = n; msg_seq = SEQ_W'(seq);
        @(negedge clk);
        ack_vld = 0; nack_vld = 0;
    endtask

    task automatic drain;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            chk(0, "R1", "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({send_go, resend_go, advance, link_restart, limit_err, tmo_stat, msg_err, hp_ovf_flag} == 8'h0,
            "R1", "outputs after reset", 0, 0);
        chk(tx_seq == 0, "R1", "tx_seq after reset", tx_seq, 0);

        // R2 / R3: send and acknowledge
        send_seg(0, "R2");
        @(negedge clk);
        expect_cmd(K_ADV, 0, 0, "R3");
        pulse_msg(1, 0, 0);
        drain();
        chk(tx_seq == 1, "R3", "tx_seq after advance", tx_seq, 1);
        chk(msg_err == 0, "R9", "msg_err while enabled", msg_err, 0);

        // R4: nack then ack
        send_seg(1, "R2");
        @(negedge clk);
        expect_cmd(K_RESEND, 1, 0, "R4");
        pulse_msg(0, 1, 1);
        @(negedge clk);
        expect_cmd(K_ADV, 1, 0, "R3");
        pulse_msg(1, 0, 1);
        drain();

        // R6: mismatched sequence numbers are ignored
        send_seg(2, "R2");
        @(negedge clk);
        pulse_msg(1, 0, 5);
        pulse_msg(0, 1, 7);
        repeat (2) @(negedge clk);
        chk(tx_seq == 2, "R6", "tx_seq after mismatched messages", tx_seq, 2);
        chk(q.size() == 0, "R6", "pending commands after mismatch", q.size(), 0);
        expect_cmd(K_ADV, 2, 0, "R3");
        pulse_msg(1, 0, 2);
        drain();

        // R5: timeout resend with exact spacing
        send_seg(3, "R2");
        expect_cmd(K_RESEND_TMO, 3, TMO + 1, "R5");
        do @(negedge clk); while (!resend_go);
        @(negedge clk);
        expect_cmd(K_ADV, 3, 0, "R3");
        pulse_msg(1, 0, 3);
        drain();

        // R7: limit via timeouts
        send_seg(4, "R2");
        for (int i = 0; i < MAXT - 1; i++) expect_cmd(K_RESEND_TMO, 4, TMO + 1, "R5");
        expect_cmd(K_RESTART, 4, TMO + 1, "R7");
        drain();
        chk(tx_seq == 4, "R7", "tx_seq after restart", tx_seq, 4);

        // R7: attempt count cleared; limit via nacks
        send_seg(4, "R7");
        for (int i = 0; i < MAXT - 1; i++) begin
            @(negedge clk);
            expect_cmd(K_RESEND, 4, 0, "R7");
            pulse_msg(0, 1, 4);
        end
        @(negedge clk);
        expect_cmd(K_RESTART, 4, 0, "R7");
        pulse_msg(0, 1, 4);
        drain();

        // R8: ack wins over nack
        send_seg(4, "R2");
        @(negedge clk);
        expect_cmd(K_ADV, 4, 0, "R8");
        pulse_msg(1, 1, 4);
        drain();
        chk(tx_seq == 5, "R8", "tx_seq after simultaneous messages", tx_seq, 5);

        // R9: retry messages while disabled
        roe_en = 0;
        @(negedge clk);
        pulse_msg(1, 0, 5);
        chk(msg_err == 1, "R9", "msg_err after ack while disabled", msg_err, 1);
        @(negedge clk);
        chk(msg_err == 0, "R9", "msg_err one cycle only", msg_err, 0);
        pulse_msg(0, 1, 3);
        chk(msg_err == 1, "R9", "msg_err after nack while disabled", msg_err, 1);
        seg_ready = 1;
        repeat (4) @(negedge clk);
        seg_ready = 0;
        repeat (2) @(negedge clk);
        chk(tx_seq == 5, "R9", "tx_seq while disabled", tx_seq, 5);

        // R10: overflow flag, disabled then enabled
        hp_ovf_evt = 1;
        @(negedge clk);
        hp_ovf_evt = 0;
        chk(hp_ovf_flag == 1, "R10", "flag after event (disabled)", hp_ovf_flag, 1);
        @(negedge clk);
        chk(hp_ovf_flag == 0, "R10", "flag drops (disabled)", hp_ovf_flag, 0);
        roe_en = 1;
        @(negedge clk);
        hp_ovf_evt = 1;
        @(negedge clk);
        hp_ovf_evt = 0;
        for (int i = 0; i < 5; i++) begin
            chk(hp_ovf_flag == 1, "R10", "flag held until drained", hp_ovf_flag, 1);
            @(negedge clk);
        end
        hp_empty = 1;
        @(negedge clk);
        hp_empty = 0;
        chk(hp_ovf_flag == 0, "R10", "flag clears after drain", hp_ovf_flag, 0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R11", "scoreboard empty at end", q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule